// File: doc/BRIEF.md
# Multi-Register Stack Transfer Sequencer

This block carries out one push-multiple or pop-multiple operation on a full-descending stack. It takes a register-selection mask, a push/pop select and the current stack pointer, all sampled together with a start strobe. It then walks the selected registers in ascending register number and makes one word access per cycle through a request/ready memory port. A push reads each register through a register-file read port and stores it. A pop loads each word and writes it to a register-file write port. When every access has been accepted, the block writes the new stack pointer back and signals completion.

Before any access is made, the block checks the mask against the rules for legal lists. A rejected list ends at once with an error and touches neither memory, the register file nor the stack pointer. When the program counter is popped, the loaded word is not written to the register file. It is turned into a branch target, or into a fault when its low bit is clear.

The sequencer has four states. ST_IDLE waits for start. It goes to ST_XFER when the list is legal and to ST_FAIL when it is not. ST_XFER issues accesses and stays there while ready is low or while registers remain. It moves to ST_DONE when the last access is accepted. ST_DONE and ST_FAIL each last one cycle and then return to ST_IDLE.

Top module: `stk_multi_seq`

## Requirements
- R1: A push of N registers writes (mem_we=1) the lowest-numbered selected register at address sp_in-4N. Each further selected register, in ascending number, goes 4 bytes higher, so the highest-numbered one lands at sp_in-4. Each stored word is the rf_rdata returned for rf_raddr equal to that register's number.
- R2: A pop of N registers reads (mem_we=0) the lowest-numbered selected register from address sp_in and ascends by 4 per register. On each accepted access to a register other than 15, rf_we is 1, rf_waddr is the register number and rf_wdata equals mem_rdata.
- R3: On completion the block drives sp_we=1 for exactly the done cycle. sp_wdata is sp_in-4N for a push and sp_in+4N for a pop, using 32-bit wrap-around arithmetic.
- R4: The first access is presented in the cycle after start is sampled. Each access accepted with mem_ready=1 is followed, if registers remain, by the next access at an address 4 higher in the next cycle.
- R5: While mem_ready is 0, mem_req stays high and mem_addr, mem_we and the register index stay unchanged. No register-file write takes place.
- R6: done is a single-cycle pulse in the cycle after the last access is accepted. busy is 1 from the cycle after start until done falls.
- R7: A list is illegal if the mask is all zero, if bit 13 (stack pointer) is set, if bit 15 (program counter) is set on a push, or if bits 14 and 15 are both set on a pop. An illegal list gives done=1 and err_list=1 in the cycle after start, with no memory access, no register-file write and no stack-pointer write.
- R8: A pop that includes register 15 does not write it to the register file. At done, if the loaded word has bit 0 = 1, branch_valid=1 and branch_target equals the word with bit 0 cleared. If bit 0 = 0, pc_fault=1 and branch_valid=0.
- R9: A start strobe that arrives while busy is 1 is ignored. The operation in progress finishes with its own addresses, data and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled in idle only) |
| op_pop | input | 1 | 1 = pop, 0 = push |
| reg_mask | input | 16 | Register selection, bit i = register i |
| sp_in | input | 32 | Current stack pointer |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_rdata | input | 32 | Load data, valid with mem_ready |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| sp_we | output | 1 | Stack-pointer write enable |
| sp_wdata | output | 32 | New stack pointer |
| done | output | 1 | Operation finished (pulse) |
| busy | output | 1 | Operation in progress |
| err_list | output | 1 | Register list rejected (with done) |
| branch_valid | output | 1 | Popped program counter gives a branch (with done) |
| branch_target | output | 32 | Halfword-aligned branch address |
| pc_fault | output | 1 | Popped program counter had bit 0 clear (with done) |

## Verification
If the cycle in which start is sampled is cycle 0, access k of a legal list is due in cycle k+1 plus the number of stall cycles inserted before it. done, the stack-pointer write and the branch or fault flags are due one cycle after the last accepted access. For an illegal list, done and err_list are due in cycle 1. The bench sets its inputs on the falling edge and compares the outputs shortly after. It counts its own accepted accesses and stall cycles to know which of these events is due, so each comparison falls in the cycle the requirement names. The cycle after every done is checked to show that done has fallen and busy is low.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam int SP_REG = 13;
    localparam int LR_REG = 14;
    localparam int PC_REG = 15;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_DONE,
        ST_FAIL
    } seq_state_t;
endpackage

// File: rtl/stk_list_check.sv
module stk_list_check
    import stk_pkg::*;
#(
    parameter int NREG = 16,
    localparam int CW = $clog2(NREG + 1)
) (
    input  logic [NREG-1:0] mask,
    input  logic            is_pop,
    output logic [CW-1:0]   count,
    output logic            illegal
);
    // population count of the selection
    always_comb begin
        count = '0;
        for (int i = 0; i < NREG; i++) begin
            count = count + CW'(mask[i]);
        end
    end

    // legality rules for the list
    logic empty_list, has_sp, push_pc, pop_pc_lr;
    always_comb begin
        empty_list = (mask == '0);
        has_sp     = mask[SP_REG];
        push_pc    = !is_pop && mask[PC_REG];
        pop_pc_lr  = is_pop && mask[PC_REG] && mask[LR_REG];
        illegal    = empty_list || has_sp || push_pc || pop_pc_lr;
    end
endmodule

// File: rtl/stk_pick_low.sv
module stk_pick_low #(
    parameter int NREG = 16,
    localparam int IW = $clog2(NREG)
) (
    input  logic [NREG-1:0] bits,
    output logic [IW-1:0]   idx,
    output logic            last
);
    // lowest set bit wins: scan from the top down
    always_comb begin
        idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (bits[i]) idx = IW'(i);
        end
    end

    // at most one bit remains
    assign last = ((bits & (bits - NREG'(1))) == '0);
endmodule

// File: rtl/stk_multi_seq.sv
module stk_multi_seq
    import stk_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4,
    localparam int IW        = $clog2(NREG),
    localparam int CW        = $clog2(NREG + 1),
    localparam int SHIFT     = $clog2(WORD_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            op_pop,
    input  logic [NREG-1:0] reg_mask,
    input  logic [XLEN-1:0] sp_in,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic            mem_ready,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [IW-1:0]   rf_raddr,
    input  logic [XLEN-1:0] rf_rdata,
    output logic            rf_we,
    output logic [IW-1:0]   rf_waddr,
    output logic [XLEN-1:0] rf_wdata,
    output logic            sp_we,
    output logic [XLEN-1:0] sp_wdata,
    output logic            done,
    output logic            busy,
    output logic            err_list,
    output logic            branch_valid,
    output logic [XLEN-1:0] branch_target,
    output logic            pc_fault
);
    localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

    seq_state_t      state_q, state_d;
    logic [NREG-1:0] rem_q;
    logic [XLEN-1:0] addr_q;
    logic [XLEN-1:0] sp_fin_q;
    logic            pop_q;
    logic            pc_hit_q;
    logic [XLEN-1:0] pc_val_q;

    logic [CW-1:0]   list_cnt;
    logic            list_bad;
    logic [IW-1:0]   cur_idx;
    logic            cur_last;
    logic [XLEN-1:0] span;
    logic            accept;
    logic            cur_is_pc;

    stk_list_check #(.NREG(NREG)) u_check (
        .mask    (reg_mask),
        .is_pop  (op_pop),
        .count   (list_cnt),
        .illegal (list_bad)
    );

    stk_pick_low #(.NREG(NREG)) u_pick (
        .bits (rem_q),
        .idx  (cur_idx),
        .last (cur_last)
    );

    assign span      = XLEN'(list_cnt) << SHIFT;
    assign accept    = (state_q == ST_XFER) && mem_ready;
    assign cur_is_pc = (cur_idx == IW'(PC_REG));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = list_bad ? ST_FAIL : ST_XFER;
            ST_XFER: if (mem_ready && cur_last) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            ST_FAIL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            rem_q    <= '0;
            addr_q   <= '0;
            sp_fin_q <= '0;
            pop_q    <= 1'b0;
            pc_hit_q <= 1'b0;
            pc_val_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                rem_q    <= reg_mask;
                pop_q    <= op_pop;
                pc_hit_q <= 1'b0;
                addr_q   <= op_pop ? sp_in : (sp_in - span);
                sp_fin_q <= op_pop ? (sp_in + span) : (sp_in - span);
            end else if (accept) begin
                rem_q  <= rem_q & (rem_q - NREG'(1));
                addr_q <= addr_q + STEP;
                if (pop_q && cur_is_pc) begin
                    pc_hit_q <= 1'b1;
                    pc_val_q <= mem_rdata;
                end
            end
        end
    end

    // outputs
    always_comb begin
        mem_req       = 1'b0;
        mem_we        = 1'b0;
        mem_addr      = addr_q;
        mem_wdata     = rf_rdata;
        rf_raddr      = cur_idx;
        rf_we         = 1'b0;
        rf_waddr      = cur_idx;
        rf_wdata      = mem_rdata;
        sp_we         = 1'b0;
        sp_wdata      = sp_fin_q;
        done          = 1'b0;
        busy          = 1'b1;
        err_list      = 1'b0;
        branch_valid  = 1'b0;
        branch_target = {pc_val_q[XLEN-1:1], 1'b0};
        pc_fault      = 1'b0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_XFER: begin
                mem_req = 1'b1;
                mem_we  = !pop_q;
                rf_we   = pop_q && mem_ready && !cur_is_pc;
            end
            ST_DONE: begin
                done         = 1'b1;
                sp_we        = 1'b1;
                branch_valid = pc_hit_q && pc_val_q[0];
                pc_fault     = pc_hit_q && !pc_val_q[0];
            end
            ST_FAIL: begin
                done     = 1'b1;
                err_list = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    // ---------------- assertions ----------------
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !cur_last) |=>
            (mem_req && mem_addr == $past(mem_addr) + STEP));

    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(rf_raddr)));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_spwb_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |-> (done && !err_list));

    p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_list |-> (!sp_we && !mem_req && !rf_we));

    p_bad_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && reg_mask[SP_REG]) |=> err_list);

    p_target_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
        branch_valid |-> (!branch_target[0] && !pc_fault && done));

    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !err_list);
endmodule

// File: tb/stk_multi_seq_tb.sv
module stk_multi_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_pop = 1'b0;
    logic [15:0] reg_mask = '0;
    logic [31:0] sp_in = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b1;
    logic [31:0] mem_rdata;
    logic [3:0]  rf_raddr;
    logic [31:0] rf_rdata;
    logic        rf_we;
    logic [3:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic        sp_we;
    logic [31:0] sp_wdata;
    logic        done, busy, err_list, branch_valid, pc_fault;
    logic [31:0] branch_target;
    logic        pop_lsb = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [31:0] rf_val(input logic [3:0] i);
        return 32'hC0DE_0000 + 32'(i) * 32'h0000_0101;
    endfunction

    assign rf_rdata  = rf_val(rf_raddr);
    assign mem_rdata = ((mem_addr ^ 32'h3C3C_0000) & ~32'h1) | {31'b0, pop_lsb};

    stk_multi_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_pop(op_pop),
        .reg_mask(reg_mask), .sp_in(sp_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .sp_we(sp_we), .sp_wdata(sp_wdata), .done(done), .busy(busy),
        .err_list(err_list), .branch_valid(branch_valid),
        .branch_target(branch_target), .pc_fault(pc_fault)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R6: watchdog expired, actual hung expected done");
        summary();
    end

    // vector table: op, mask, sp, stall, popped low bit
    localparam int NV = 13;
    localparam logic        V_POP  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0,
                                            1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam logic [15:0] V_MASK [NV] = '{16'h00F1, 16'h4004, 16'h8401, 16'h1FFF,
                                            16'h8000, 16'h0001, 16'h4000, 16'h4002,
                                            16'h0000, 16'h2001, 16'h8001, 16'hC000,
                                            16'h5FFF};
    localparam logic [31:0] V_SP   [NV] = '{32'h2000_1000, 32'h2000_0800, 32'h2000_0F00,
                                            32'h1000_0040, 32'h2000_0200, 32'h0000_0010,
                                            32'h3000_0000, 32'h3000_0100, 32'h2000_0000,
                                            32'h2000_0000, 32'h2000_0000, 32'h2000_0000,
                                            32'h0000_0020};
    localparam bit          V_STL  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1,
                                            1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
    localparam bit          V_LSB  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0,
                                            1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

    task automatic do_op(input logic pop, input logic [15:0] mask, input logic [31:0] sp,
                         input bit stall, input bit lsb, input bit poke);
        bit          bad;
        int          n;
        int          k;
        int          cyc;
        logic [15:0] rem;
        logic [3:0]  idx;
        logic [31:0] base, fin, exp_addr, pc_word;
        bit          pc_seen;
        bit          rdy;
        // R7 legality rules, from the requirement
        bad = (mask == 16'h0) || mask[13] || (!pop && mask[15]) ||
              (pop && mask[15] && mask[14]);
        n    = $countones(mask);
        base = pop ? sp : sp - 32'(4 * n);
        fin  = pop ? sp + 32'(4 * n) : sp - 32'(4 * n);
        @(negedge clk);
        op_pop = pop; reg_mask = mask; sp_in = sp; pop_lsb = lsb;
        mem_ready = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (bad) begin
            #1;
            chk(done && err_list, "R7 err flag", {30'b0, done, err_list}, 32'h3);
            chk(!mem_req && !sp_we && !rf_we, "R7 no side effect",
                {29'b0, mem_req, sp_we, rf_we}, 32'h0);
            @(negedge clk); #1;
            chk(!done && !busy && !mem_req, "R6 idle after error",
                {30'b0, done, busy}, 32'h0);
            return;
        end
        k = 0; cyc = 0; rem = mask; pc_seen = 1'b0; pc_word = '0;
        while (k < n) begin
            rdy = !(stall && (cyc % 3 == 1));
            mem_ready = rdy;
            start = (poke && cyc == 1);
            if (poke && cyc == 1) reg_mask = 16'h0000;
            #1;
            idx = 4'd0;
            for (int i = 15; i >= 0; i--) if (rem[i]) idx = 4'(i);
            exp_addr = base + 32'(4 * k);
            chk(mem_req && !done, "R4 access valid", {31'b0, mem_req}, 32'h1);
            chk(mem_addr == exp_addr, pop ? "R2 pop address" : "R1 push address",
                mem_addr, exp_addr);
            chk(mem_we == !pop, "R1 R2 direction", {31'b0, mem_we}, {31'b0, !pop});
            if (!pop) begin
                chk(rf_raddr == idx, "R1 read index", {28'b0, rf_raddr}, {28'b0, idx});
                chk(mem_wdata == rf_val(idx), "R1 store data", mem_wdata, rf_val(idx));
            end else if (!rdy) begin
                chk(!rf_we, "R5 no write in stall", {31'b0, rf_we}, 32'h0);
            end else if (idx == 4'd15) begin
                chk(!rf_we, "R8 pc not written", {31'b0, rf_we}, 32'h0);
                pc_seen = 1'b1;
                pc_word = mem_rdata;
            end else begin
                chk(rf_we && rf_waddr == idx, "R2 write index",
                    {27'b0, rf_we, rf_waddr}, {27'b0, 1'b1, idx});
                chk(rf_wdata == mem_rdata, "R2 write data", rf_wdata, mem_rdata);
            end
            if (rdy) begin
                rem[idx] = 1'b0;
                k++;
            end
            cyc++;
            @(negedge clk);
        end
        mem_ready = 1'b1; start = 1'b0;
        #1;
        chk(done && busy && !err_list && !mem_req, "R6 done after last",
            {28'b0, done, busy, err_list, mem_req}, 32'hC);
        chk(sp_we && sp_wdata == fin, "R3 sp writeback", sp_wdata, fin);
        chk(branch_valid == (pc_seen && lsb), "R8 branch valid",
            {31'b0, branch_valid}, {31'b0, pc_seen && lsb});
        chk(pc_fault == (pc_seen && !lsb), "R8 pc fault",
            {31'b0, pc_fault}, {31'b0, pc_seen && !lsb});
        if (pc_seen && lsb)
            chk(branch_target == (pc_word & ~32'h1), "R8 target", branch_target,
                pc_word & ~32'h1);
        @(negedge clk); #1;
        chk(!done && !busy && !sp_we, "R6 done is a pulse",
            {29'b0, done, busy, sp_we}, 32'h0);
        if (poke)
            chk(!err_list, "R9 start ignored while busy", {31'b0, err_list}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!done && !busy && !mem_req && !sp_we && !rf_we, "R6 reset state",
            {27'b0, done, busy, mem_req, sp_we, rf_we}, 32'h0);
        rst_n = 1'b1;
        for (int v = 0; v < NV; v++) begin
            do_op(V_POP[v], V_MASK[v], V_SP[v], V_STL[v], V_LSB[v], 1'b0);
        end
        // R9: a start during a transfer must not disturb it
        do_op(1'b0, 16'h10F0, 32'h2000_4000, 1'b0, 1'b0, 1'b1);
        do_op(1'b1, 16'h10F0, 32'h2000_3FEC, 1'b1, 1'b0, 1'b1);
        // R5: long stall run on a pop with the program counter
        do_op(1'b1, 16'h8003, 32'h4000_0000, 1'b1, 1'b1, 1'b0);
        repeat (2) @(negedge clk);
        summary();
    end
endmodule